// File: doc/BRIEF.md
# Multiplexed Pixel Input Deskew Aligner

This block sits on the input side of a binary-mirror exposure array. Gray pixel data arrives over a narrow bus. Each input wire carries the gray value of one driven pixel-row, one bit per beat, over `BITS` consecutive phases. A phase index travels with each beat. The block rebuilds the full gray value of every row. It then splits the value into its bits and holds back each bit by its own number of lines. The hold-back for bit k equals the column where that bit's block begins, counted from the array entry. With blocks of `BLK_N * 2^k` columns placed in bit order, this is `BLK_N * (2^k - 1)` lines. The result is that every bit enters its own binary-weighted block in step with the moving target spot.

Each non-zero hold-back is a ring buffer. It uses a single pointer that wraps at the buffer depth and reads each slot before overwriting it, so the storage can map onto block RAM. Bit 0 needs no hold-back and passes through a plain register. The output stage copies every driven row onto `FANOUT` neighbouring array rows.

Top module: `pxa_deskew_aligner`

## Requirements
- R1: While reset is high and in the cycle after it falls, `frame_err_o`, `line_vld_o` and every bit of `array_bits_o` are 0.
- R2: A beat is taken only when `beat_vld_i` is high. Its phase must equal the expected phase, which starts at 0 and rises by one per accepted beat. Bit `beat_data_i[r]` of an accepted beat with phase p becomes bit p of the gray value of input row r.
- R3: `line_vld_o` is high for exactly one cycle. That cycle begins two clock edges after the edge that samples the accepted beat with phase `BITS-1`. `line_vld_o` is high at no other time.
- R4: With line n counted as the n-th pulse of `line_vld_o` (the first pulse is line 0), bit k presented on line n is bit k of the gray value completed on line n - `BLK_N*(2^k-1)`.
- R5: On any line n below `BLK_N*(2^k-1)`, every output copy of bit k is 0.
- R6: Bit k of input row r appears at `array_bits_o[(r*FANOUT + j)*BITS + k]` for every j from 0 to `FANOUT-1`.
- R7: A valid beat whose phase differs from the expected one (including any phase of `BITS` or more) does three things. It raises `frame_err_o` for exactly one cycle, one edge later. It drops the partly built value. It sets the expected phase back to 0.
- R8: Cycles with `beat_vld_i` low change nothing. Between `line_vld_o` pulses, `array_bits_o` holds its value.
- R9: Bit 0 has no hold-back: it shows the gray value of the line just completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| beat_vld_i | input | 1 | The beat on this cycle is valid |
| beat_phase_i | input | PH_W | Bit position carried by the beat |
| beat_data_i | input | NUM_IN | One bit per driven input row |
| frame_err_o | output | 1 | One-cycle pulse for a beat out of sequence |
| line_vld_o | output | 1 | One-cycle pulse when a new line is presented |
| array_bits_o | output | NUM_IN*FANOUT*BITS | Aligned bits for every array row, BITS bits per row |

## Verification
The bench builds the block with 4 input rows, a fan-out of 2, 5 bits and a block unit of 1. That gives hold-backs of 0, 1, 3, 7 and 15 lines. About two dozen lines are enough to fill the deepest ring and watch it wrap, so both the zero-fill period and the steady delayed output of every bit are covered. The small width keeps each array bit checked on its own every cycle. The bench also exercises a 1-deep ring and the register bypass of bit 0. It mixes idle gaps and out-of-sequence phases into the beat stream.

// File: rtl/pxa_pkg.sv
package pxa_pkg;

  // Line hold-back for bit k when block k is unit*2^k columns wide and
  // blocks are laid out from the array entry in ascending bit order.
  function automatic int unsigned bit_delay(input int unsigned k, input int unsigned unit);
    return unit * ((32'd1 << k) - 32'd1);
  endfunction

endpackage

// File: rtl/pxa_phase_capture.sv
module pxa_phase_capture #(
  parameter int unsigned NUM_IN = 16,
  parameter int unsigned BITS   = 5,
  parameter int unsigned PH_W   = 3
) (
  input  logic                         clk_i,
  input  logic                         rst_i,
  input  logic                         beat_vld_i,
  input  logic [PH_W-1:0]              beat_phase_i,
  input  logic [NUM_IN-1:0]            beat_data_i,
  output logic [BITS-1:0][NUM_IN-1:0]  pix_bits_o,
  output logic                         pix_vld_o,
  output logic                         frame_err_o
);

  localparam logic [PH_W-1:0] LAST_PH = PH_W'(BITS - 1);

  logic [PH_W-1:0]             exp_q;
  logic [BITS-1:0][NUM_IN-1:0] acc_q;
  logic [BITS-1:0][NUM_IN-1:0] pix_q;
  logic                        pix_vld_q;
  logic                        err_q;
  logic                        hit;

  assign hit = beat_vld_i && (beat_phase_i == exp_q);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      exp_q     <= '0;
      acc_q     <= '0;
      pix_q     <= '0;
      pix_vld_q <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      pix_vld_q <= 1'b0;
      err_q     <= 1'b0;
      if (beat_vld_i) begin
        if (hit) begin
          if (exp_q == LAST_PH) begin
            for (int k = 0; k < BITS; k++) begin
              if (k == BITS - 1) pix_q[k] <= beat_data_i;
              else               pix_q[k] <= acc_q[k];
            end
            pix_vld_q <= 1'b1;
            exp_q     <= '0;
          end else begin
            acc_q[exp_q] <= beat_data_i;
            exp_q        <= exp_q + 1'b1;
          end
        end else begin
          err_q <= 1'b1;
          exp_q <= '0;
        end
      end
    end
  end

  assign pix_bits_o  = pix_q;
  assign pix_vld_o   = pix_vld_q;
  assign frame_err_o = err_q;

  // R2
  exp_in_range_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    exp_q <= LAST_PH);

  // R2
  pix_after_last_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    pix_vld_q |-> $past(beat_vld_i && (beat_phase_i == LAST_PH)));

  // R3
  pix_no_repeat_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    pix_vld_q |=> !pix_vld_q);

  // R7
  err_cause_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    err_q |-> ($past(beat_vld_i) && (exp_q == '0)));

endmodule

// File: rtl/pxa_ring_delay.sv
module pxa_ring_delay #(
  parameter int unsigned WIDTH = 16,
  parameter int unsigned DEPTH = 1
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             adv_i,
  input  logic [WIDTH-1:0] din_i,
  output logic [WIDTH-1:0] dout_o
);

  if (DEPTH == 0) begin : g_bypass
    logic [WIDTH-1:0] q;
    always_ff @(posedge clk_i) begin
      if (rst_i)      q <= '0;
      else if (adv_i) q <= din_i;
    end
    assign dout_o = q;
  end else begin : g_ring
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [WIDTH-1:0] rd_q;
    logic [PTR_W-1:0] ptr_q;
    logic [CNT_W-1:0] fill_q;
    logic             primed_q;

    // Read-first RAM port: old slot content leaves as new content lands.
    always_ff @(posedge clk_i) begin
      if (adv_i) begin
        rd_q       <= mem[ptr_q];
        mem[ptr_q] <= din_i;
      end
    end

    always_ff @(posedge clk_i) begin
      if (rst_i) begin
        ptr_q    <= '0;
        fill_q   <= '0;
        primed_q <= 1'b0;
      end else if (adv_i) begin
        ptr_q    <= (ptr_q == PTR_LAST) ? '0 : ptr_q + 1'b1;
        primed_q <= (fill_q == CNT_FULL);
        if (fill_q != CNT_FULL) fill_q <= fill_q + 1'b1;
      end
    end

    assign dout_o = primed_q ? rd_q : '0;

    // R4
    ptr_in_range_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      ptr_q <= PTR_LAST);

    // R5
    primed_sticky_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      primed_q |=> primed_q);

    // R5
    fill_bound_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      fill_q <= CNT_FULL);
  end

endmodule

// File: rtl/pxa_fanout.sv
module pxa_fanout #(
  parameter int unsigned NUM_IN = 16,
  parameter int unsigned FANOUT = 4,
  parameter int unsigned BITS   = 5
) (
  input  logic [BITS-1:0][NUM_IN-1:0]     bits_i,
  output logic [NUM_IN*FANOUT*BITS-1:0]   rows_o
);

  for (genvar r = 0; r < NUM_IN; r++) begin : g_row
    for (genvar j = 0; j < FANOUT; j++) begin : g_copy
      for (genvar k = 0; k < BITS; k++) begin : g_bit
        assign rows_o[(r*FANOUT + j)*BITS + k] = bits_i[k][r];
      end
    end
  end

endmodule

// File: rtl/pxa_deskew_aligner.sv
module pxa_deskew_aligner #(
  parameter int unsigned NUM_IN = 16,
  parameter int unsigned FANOUT = 4,
  parameter int unsigned BITS   = 5,
  parameter int unsigned BLK_N  = 1,
  parameter int unsigned PH_W   = $clog2(BITS),
  parameter int unsigned OUT_W  = NUM_IN * FANOUT * BITS
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              beat_vld_i,
  input  logic [PH_W-1:0]   beat_phase_i,
  input  logic [NUM_IN-1:0] beat_data_i,
  output logic              frame_err_o,
  output logic              line_vld_o,
  output logic [OUT_W-1:0]  array_bits_o
);

  logic [BITS-1:0][NUM_IN-1:0] pix_bits;
  logic [BITS-1:0][NUM_IN-1:0] dly_bits;
  logic                        pix_vld;
  logic                        line_vld_q;

  pxa_phase_capture #(
    .NUM_IN (NUM_IN),
    .BITS   (BITS),
    .PH_W   (PH_W)
  ) capture_i (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .beat_vld_i   (beat_vld_i),
    .beat_phase_i (beat_phase_i),
    .beat_data_i  (beat_data_i),
    .pix_bits_o   (pix_bits),
    .pix_vld_o    (pix_vld),
    .frame_err_o  (frame_err_o)
  );

  for (genvar k = 0; k < BITS; k++) begin : g_bit
    localparam int unsigned DLY = pxa_pkg::bit_delay(k, BLK_N);
    pxa_ring_delay #(
      .WIDTH (NUM_IN),
      .DEPTH (DLY)
    ) ring_i (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .adv_i  (pix_vld),
      .din_i  (pix_bits[k]),
      .dout_o (dly_bits[k])
    );
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) line_vld_q <= 1'b0;
    else       line_vld_q <= pix_vld;
  end

  pxa_fanout #(
    .NUM_IN (NUM_IN),
    .FANOUT (FANOUT),
    .BITS   (BITS)
  ) fanout_i (
    .bits_i (dly_bits),
    .rows_o (array_bits_o)
  );

  assign line_vld_o = line_vld_q;

  // R3
  line_follows_pix_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    line_vld_o |-> $past(pix_vld));

  // R8
  bits_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !pix_vld |=> $stable(array_bits_o));

endmodule

// File: tb/pxa_deskew_aligner_tb_top.sv
module pxa_deskew_aligner_tb_top;

  localparam int NUM_IN = 4;
  localparam int FANOUT = 2;
  localparam int BITS   = 5;
  localparam int BLK_N  = 1;
  localparam int PH_W   = 3;
  localparam int OUT_W  = NUM_IN * FANOUT * BITS;
  localparam int PIX_W  = NUM_IN * BITS;

  logic              clk = 1'b0;
  logic              rst_i;
  logic              beat_vld_i;
  logic [PH_W-1:0]   beat_phase_i;
  logic [NUM_IN-1:0] beat_data_i;
  logic              frame_err_o;
  logic              line_vld_o;
  logic [OUT_W-1:0]  array_bits_o;

  always #10 clk = ~clk;

  pxa_deskew_aligner #(
    .NUM_IN (NUM_IN),
    .FANOUT (FANOUT),
    .BITS   (BITS),
    .BLK_N  (BLK_N),
    .PH_W   (PH_W)
  ) dut_i (
    .clk_i        (clk),
    .rst_i        (rst_i),
    .beat_vld_i   (beat_vld_i),
    .beat_phase_i (beat_phase_i),
    .beat_data_i  (beat_data_i),
    .frame_err_o  (frame_err_o),
    .line_vld_o   (line_vld_o),
    .array_bits_o (array_bits_o)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  // Reference model state
  logic [PIX_W-1:0] hist[$];
  logic [PIX_W-1:0] m_acc = '0;
  logic [PIX_W-1:0] m_pix = '0;
  logic             m_pix_vld = 1'b0;
  int               m_exp = 0;
  int               e_lcur = -1;
  logic             e_line = 1'b0;
  logic             e_err = 1'b0;
  logic [OUT_W-1:0] e_bits = '0;

  function automatic int dly(input int k);
    return BLK_N * ((1 << k) - 1);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic compare(input bit idle);
    chk(line_vld_o == e_line, "R3 line_vld_o", 64'(line_vld_o), 64'(e_line));
    chk(frame_err_o == e_err, "R7 frame_err_o", 64'(frame_err_o), 64'(e_err));
    for (int p = 0; p < OUT_W; p++) begin
      int row = p / BITS;
      int k   = p % BITS;
      int j   = row % FANOUT;
      string tag;
      if (j != 0)                        tag = "R6 fanout copy";
      else if (k == 0)                   tag = "R2 R9 bit0";
      else if (e_lcur < dly(k))          tag = "R5 zero fill";
      else                               tag = "R4 delayed bit";
      chk(array_bits_o[p] == e_bits[p], $sformatf("%s pos %0d", tag, p),
          64'(array_bits_o[p]), 64'(e_bits[p]));
    end
    if (idle && !e_line)
      chk(array_bits_o == e_bits, "R8 hold while idle", 64'(array_bits_o), 64'(e_bits));
  endtask

  task automatic step(input bit vld, input int ph, input logic [NUM_IN-1:0] data);
    @(negedge clk);
    compare(!vld);
    beat_vld_i   = vld;
    beat_phase_i = PH_W'(ph);
    beat_data_i  = data;
    // advance model by one clock edge
    e_line = m_pix_vld;
    if (m_pix_vld) begin
      hist.push_back(m_pix);
      e_lcur = hist.size() - 1;
      for (int r = 0; r < NUM_IN; r++) begin
        for (int k = 0; k < BITS; k++) begin
          logic b;
          b = (e_lcur >= dly(k)) ? hist[e_lcur - dly(k)][r*BITS + k] : 1'b0;
          for (int j = 0; j < FANOUT; j++) e_bits[(r*FANOUT + j)*BITS + k] = b;
        end
      end
    end
    e_err = 1'b0;
    m_pix_vld = 1'b0;
    if (vld) begin
      if (ph == m_exp) begin
        for (int r = 0; r < NUM_IN; r++) m_acc[r*BITS + ph] = data[r];
        if (m_exp == BITS - 1) begin
          m_pix = m_acc;
          m_pix_vld = 1'b1;
          m_exp = 0;
        end else begin
          m_exp++;
        end
      end else begin
        e_err = 1'b1;
        m_exp = 0;
      end
    end
  endtask

  function automatic logic [NUM_IN-1:0] pat(input int l, input int p);
    return NUM_IN'((l * 7 + p * 3 + 5) ^ (l >> 1) ^ (p * l));
  endfunction

  task automatic send_line(input int l, input int gap);
    for (int p = 0; p < BITS; p++) begin
      step(1'b1, p, pat(l, p));
      for (int g = 0; g < gap; g++) step(1'b0, 0, '0);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      checks++;
      fails++;
      $display("FAIL watchdog R3 actual=%0d expected=%0d", cyc, 20000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_i        = 1'b1;
    beat_vld_i   = 1'b0;
    beat_phase_i = '0;
    beat_data_i  = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(line_vld_o == 1'b0, "R1 line_vld_o", 64'(line_vld_o), 64'd0);
    chk(frame_err_o == 1'b0, "R1 frame_err_o", 64'(frame_err_o), 64'd0);
    chk(array_bits_o == '0, "R1 array_bits_o", 64'(array_bits_o), 64'd0);
    rst_i = 1'b0;

    // All-ones first lines stress zero fill of later bits (R5)
    for (int p = 0; p < BITS; p++) step(1'b1, p, '1);
    for (int l = 1; l < 10; l++) send_line(l, l % 3);

    // R7: out-of-sequence phase mid line
    step(1'b1, 0, 4'hA);
    step(1'b1, 1, 4'h5);
    step(1'b1, 3, 4'hF);
    send_line(10, 0);
    // R7: phase beyond range
    step(1'b1, 7, 4'h3);
    // R7: restart phase while expecting 3
    step(1'b1, 0, 4'h1);
    step(1'b0, 0, '0);
    step(1'b1, 1, 4'h2);
    step(1'b1, 2, 4'h4);
    step(1'b1, 0, 4'h8);
    for (int l = 11; l < 30; l++) send_line(l, (l % 4 == 0) ? 2 : 0);
    // R4 wrap of deepest ring, then drain
    for (int i = 0; i < 4; i++) step(1'b0, 0, '0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule